// File: doc/BRIEF.md
# Seconds-Tick Reset Watchdog

This block is a watchdog that counts down once per slow tick, normally a one-second strobe. Software arms it by writing a nonzero reload value into the count register, and keeps it alive by writing that value again before the count runs out. Writing zero stops it. When the count runs out, the block sets a sticky expiry flag and drives a reset output for a fixed number of clock cycles.

The count advances only when the configuration register selects watchdog-with-reset operation and the one-second source. Any other configuration holds the count where it is. The block has one side effect that software must allow for: any read of the status register clears the count, which stops the watchdog. Software that reads status while the watchdog is in use must reload the count afterwards.

All access is through a byte-wide register port. A write takes effect at the next clock edge. Read data is combinational and shows the register state before that edge.

Top module: `sec_watchdog`

## Requirements
- R1: After reset the count, the configuration register, the expiry flag and the reset output are all zero.
- R2: A write of a nonzero byte to the count register (address 3) loads that value at the next edge. A read of the count register returns the live remaining count and does not change it.
- R3: A write of zero to the count register stops the watchdog. Ticks that follow change nothing and cause no expiry.
- R4: Each tick pulse lowers a nonzero count by one, but only while the configuration register (address 2) holds 2'b11 in bits 7:6 and 2'b10 in bits 1:0. With any other setting, ticks leave the count unchanged.
- R5: A counting tick that arrives while the count is 1 makes the count 0 and sets the expiry flag. The flag is output `wdFlag` and also bit 6 of the status register (address 1). From the next clock cycle, `resetOut` is high for exactly RST_CYCLES (default 4) clock cycles.
- R6: Once the count is 0, it stays 0 under further ticks, and no new expiry or reset pulse occurs.
- R7: Any read of the status register (address 1) clears the count to 0 at that edge. The watchdog is then stopped.
- R8: A write to the status register with bit 6 = 0 clears the expiry flag. A write with bit 6 = 1 leaves the flag unchanged.
- R9: A count-register write in the same cycle as a counting tick loads the written value, and no decrement is applied in that cycle.
- R10: If an expiry and a flag-clearing write to the status register fall in the same cycle, the flag ends up set.
- R11: The configuration register (address 2) reads back the byte last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe, one cycle |
| regRdEn | input | 1 | Register read strobe, one cycle |
| regAddr | input | ADDR_W | Register address: 1 status, 2 configuration, 3 count |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational from address |
| tickIn | input | 1 | One-clock pulse per second |
| wdFlag | output | 1 | Sticky expiry flag |
| resetOut | output | 1 | Reset pulse driven on expiry |

## Verification
Writes, status-read clears and tick decrements all reach the count and flag at the first clock edge after the strobe. The bench therefore drives every stimulus on a falling edge and checks the result on the following falling edge. Read data is combinational, so it is sampled one time unit after the read strobe is driven, before the edge that would apply a status-read clear. The reset pulse rises at the same edge that sets the flag. The bench counts the falling edges on which it stays high, starting at the sample right after the expiry tick.

// File: rtl/sec_wdog_pkg.sv
package sec_wdog_pkg;

  // Register addresses; software decodes the flag at bit 6 of the status register.
  localparam int ADDR_STATUS = 1;
  localparam int ADDR_CFG    = 2;
  localparam int ADDR_COUNT  = 3;
  localparam int FLAG_BIT    = 6;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;     // load count from write data
    logic clear;    // clear count (status-read side effect)
    logic dec;      // decrement count by one
    logic flagSet;  // expiry
    logic flagClr;  // software clear of the flag
  } wdStrb_t;

endpackage

// File: rtl/sec_wdog_ctrl.sv
module sec_wdog_ctrl
  import sec_wdog_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic              tickIn,
  input  logic              countIsZero,
  input  logic              countIsOne,
  output wdStrb_t           strb,
  output logic [7:0]        cfgVal,
  output logic              resetOut
);

  localparam int PW = $clog2(RST_CYCLES + 1);

  logic       hitStatus, hitCfg, hitCount;
  logic       runEn;
  logic [7:0] cfgQ;
  logic [PW-1:0] pulseCnt;

  assign hitStatus = (regAddr == ADDR_W'(ADDR_STATUS));
  assign hitCfg    = (regAddr == ADDR_W'(ADDR_CFG));
  assign hitCount  = (regAddr == ADDR_W'(ADDR_COUNT));

  // Count only with watchdog+reset mode and the one-second source selected.
  assign runEn = (cfgQ[7:6] == 2'b11) && (cfgQ[1:0] == 2'b10);

  always_comb begin
    strb.load    = regWrEn && hitCount;
    strb.clear   = regRdEn && hitStatus && !strb.load;
    strb.dec     = tickIn && runEn && !countIsZero && !strb.load && !strb.clear;
    strb.flagSet = strb.dec && countIsOne;
    strb.flagClr = regWrEn && hitStatus && !regWrData[FLAG_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (regWrEn && hitCfg) begin
      cfgQ <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strb.flagSet) begin
      pulseCnt <= PW'(RST_CYCLES);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign cfgVal   = cfgQ;
  assign resetOut = (pulseCnt != '0);

endmodule

// File: rtl/sec_wdog_dp.sv
module sec_wdog_dp
  import sec_wdog_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdStrb_t           strb,
  input  logic [CNT_W-1:0]  loadVal,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        cfgVal,
  output logic [CNT_W-1:0]  countVal,
  output logic              countIsZero,
  output logic              countIsOne,
  output logic              wdFlag,
  output logic [7:0]        rdData
);

  logic [CNT_W-1:0] countQ;
  logic             flagQ;

  // Priority: load, then status-read clear, then decrement.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strb.load) begin
      countQ <= loadVal;
    end else if (strb.clear) begin
      countQ <= '0;
    end else if (strb.dec) begin
      countQ <= countQ - 1'b1;
    end
  end

  // Expiry wins over a same-cycle software clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (strb.flagSet) begin
      flagQ <= 1'b1;
    end else if (strb.flagClr) begin
      flagQ <= 1'b0;
    end
  end

  assign countIsZero = (countQ == '0);
  assign countIsOne  = (countQ == CNT_W'(1));
  assign countVal    = countQ;
  assign wdFlag      = flagQ;

  always_comb begin
    rdData = '0;
    if (regAddr == ADDR_W'(ADDR_STATUS)) begin
      rdData[FLAG_BIT] = flagQ;
    end else if (regAddr == ADDR_W'(ADDR_CFG)) begin
      rdData = cfgVal;
    end else if (regAddr == ADDR_W'(ADDR_COUNT)) begin
      rdData = 8'(countQ);
    end
  end

endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog
  import sec_wdog_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int CNT_W      = 8,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              tickIn,
  output logic              wdFlag,
  output logic              resetOut
);

  wdStrb_t          strb;
  logic [7:0]       cfgVal;
  logic [CNT_W-1:0] countVal;
  logic             countIsZero;
  logic             countIsOne;

  sec_wdog_ctrl #(
    .ADDR_W    (ADDR_W),
    .RST_CYCLES(RST_CYCLES)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .tickIn     (tickIn),
    .countIsZero(countIsZero),
    .countIsOne (countIsOne),
    .strb       (strb),
    .cfgVal     (cfgVal),
    .resetOut   (resetOut)
  );

  sec_wdog_dp #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .loadVal    (CNT_W'(regWrData)),
    .regAddr    (regAddr),
    .cfgVal     (cfgVal),
    .countVal   (countVal),
    .countIsZero(countIsZero),
    .countIsOne (countIsOne),
    .wdFlag     (wdFlag),
    .rdData     (regRdData)
  );

endmodule

// File: rtl/sec_watchdog_chk.sv
module sec_watchdog_chk
  import sec_wdog_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int CNT_W      = 8,
  parameter int RST_CYCLES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regWrData,
  input logic              tickIn,
  input logic [CNT_W-1:0]  countVal,
  input logic              wdFlag,
  input logic              resetOut
);

  logic wrCount, rdStatus;
  int unsigned highRun;

  assign wrCount  = regWrEn && (regAddr == ADDR_W'(ADDR_COUNT));
  assign rdStatus = regRdEn && (regAddr == ADDR_W'(ADDR_STATUS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highRun <= 0;
    end else if (resetOut) begin
      highRun <= highRun + 1;
    end else begin
      highRun <= 0;
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrCount |=> countVal == $past(CNT_W'(regWrData)));

  assert_status_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !wrCount) |=> countVal == '0);

  assert_hold_at_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (countVal == '0 && !wrCount) |=> countVal == '0);

  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!wrCount && !rdStatus) |=>
      (countVal == $past(countVal)) || (countVal == CNT_W'($past(countVal) - 1'b1)));

  assert_expiry_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdFlag) |-> resetOut && countVal == '0 && $past(countVal) == CNT_W'(1)
                      && $past(tickIn));

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    highRun <= RST_CYCLES);

endmodule

bind sec_watchdog sec_watchdog_chk #(
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W),
  .RST_CYCLES(RST_CYCLES)
) chk_i (.*);

// File: tb/sec_watchdog_tb.sv
`timescale 1ns/1ps
module sec_watchdog_tb_top;

  localparam int ADDR_W = 2;
  localparam int RST_CYCLES = 4;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CFG  = 2'd2;
  localparam logic [1:0] A_CNT  = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic regRdEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic tickIn = 1'b0;
  logic wdFlag;
  logic resetOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sec_watchdog #(.ADDR_W(ADDR_W), .CNT_W(8), .RST_CYCLES(RST_CYCLES)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .tickIn(tickIn), .wdFlag(wdFlag), .resetOut(resetOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One bus cycle; inputs driven on a falling edge, read data sampled 1 ns later.
  task automatic op(input logic wr, input logic rd, input logic [1:0] addr,
                    input logic [7:0] data, input logic tk, output logic [7:0] rdv);
    @(negedge clk);
    regWrEn = wr; regRdEn = rd; regAddr = addr; regWrData = data; tickIn = tk;
    #1 rdv = regRdData;
    @(negedge clk);
    regWrEn = 0; regRdEn = 0; tickIn = 0;
  endtask

  task automatic wr(input logic [1:0] addr, input logic [7:0] data);
    logic [7:0] d;
    op(1, 0, addr, data, 0, d);
  endtask

  task automatic rdv(input logic [1:0] addr, output logic [7:0] v);
    op(0, 1, addr, 8'h00, 0, v);
  endtask

  task automatic tick();
    logic [7:0] d;
    op(0, 0, 2'd0, 8'h00, 1, d);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 resetOut", resetOut, 0);
    check("R1 wdFlag", wdFlag, 0);
    rdv(A_CNT, v); check("R1 count", v, 0);
    rdv(A_CFG, v); check("R1 cfg", v, 0);
    rdv(A_STAT, v); check("R1 status", v, 0);
  endtask

  task automatic t_load_count();
    logic [7:0] v;
    wr(A_CFG, 8'hC2);
    rdv(A_CFG, v); check("R11 cfg readback", v, 8'hC2);
    wr(A_CNT, 8'd5);
    rdv(A_CNT, v); check("R2 loaded count", v, 5);
    rdv(A_CNT, v); check("R2 read keeps count", v, 5);
    tick(); tick();
    rdv(A_CNT, v); check("R4 two ticks", v, 3);
  endtask

  task automatic t_cfg_gating();
    logic [7:0] v;
    wr(A_CFG, 8'hC1); tick();
    rdv(A_CNT, v); check("R4 wrong source holds", v, 3);
    wr(A_CFG, 8'h82); tick();
    rdv(A_CNT, v); check("R4 wrong mode holds", v, 3);
    wr(A_CFG, 8'hC2); tick();
    rdv(A_CNT, v); check("R4 counting resumes", v, 2);
  endtask

  task automatic t_stop();
    logic [7:0] v;
    wr(A_CNT, 8'd0); tick(); tick();
    rdv(A_CNT, v); check("R3 stopped count", v, 0);
    check("R3 no flag", wdFlag, 0);
    check("R3 no reset", resetOut, 0);
  endtask

  task automatic t_expiry();
    logic [7:0] v;
    int high;
    wr(A_CNT, 8'd2); tick();
    rdv(A_CNT, v); check("R5 before expiry", v, 1);
    tick();
    check("R5 flag set", wdFlag, 1);
    high = 0;
    while (resetOut && high < 20) begin
      high++;
      @(negedge clk);
    end
    check("R5 reset pulse length", high, RST_CYCLES);
    rdv(A_CNT, v); check("R5 count at zero", v, 0);
    tick(); tick();
    rdv(A_CNT, v); check("R6 count holds zero", v, 0);
    check("R6 no new reset", resetOut, 0);
  endtask

  task automatic t_flag_clear();
    logic [7:0] v;
    wr(A_STAT, 8'h40);
    check("R8 bit6 one keeps flag", wdFlag, 1);
    rdv(A_STAT, v); check("R8 status bit6", v, 8'h40);
    wr(A_STAT, 8'h00);
    check("R8 bit6 zero clears flag", wdFlag, 0);
    rdv(A_STAT, v); check("R8 status after clear", v, 0);
  endtask

  task automatic t_status_read_clear();
    logic [7:0] v;
    wr(A_CNT, 8'd9);
    rdv(A_STAT, v);
    rdv(A_CNT, v); check("R7 status read clears count", v, 0);
    tick();
    rdv(A_CNT, v); check("R7 watchdog stopped", v, 0);
    check("R7 no flag", wdFlag, 0);
  endtask

  task automatic t_write_vs_tick();
    logic [7:0] v;
    logic [7:0] d;
    wr(A_CNT, 8'd4);
    op(1, 0, A_CNT, 8'd7, 1, d);
    rdv(A_CNT, v); check("R9 write wins over tick", v, 7);
  endtask

  task automatic t_set_vs_clear();
    logic [7:0] d;
    wr(A_CNT, 8'd1);
    op(1, 0, A_STAT, 8'h00, 1, d);
    check("R10 expiry beats clear", wdFlag, 1);
    check("R10 reset pulse starts", resetOut, 1);
    repeat (RST_CYCLES + 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_load_count();
    t_cfg_gating();
    t_stop();
    t_expiry();
    t_flag_clear();
    t_status_read_clear();
    t_write_vs_tick();
    t_set_vs_clear();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule